// File: doc/BRIEF.md
# Digit-Serial Redundant-Basis Field Multiplier

This block multiplies two finite-field elements that are both held in redundant-basis form. Each element has `N` coordinates in the ring GF(2)[x]/(x^N − 1). The product is therefore a cyclic convolution over GF(2), and no modular reduction step is needed. Operand B is captured in parallel into a circular register. Operand A arrives `W` coordinates per clock. One AND-XOR accumulator per product coordinate builds up the result. The full product word is presented in parallel once every digit of A has been consumed.

A multiplication starts with a one-cycle `start` strobe that carries B on `b_in`. The caller then presents `ceil(N/W)` digits of A, lowest coordinates first. Each digit is consumed on a clock edge where `a_valid` is high. The caller may insert idle cycles between digits. `done` pulses once, and the product then stays on `prod` until the next `start`. Conversion to and from other bases is not part of this block. Squaring and inversion are also outside it.

Top module: `rb_dsmul`

## Requirements
- R1: After reset, `prod` is all zeros and `done` is low.
- R2: A cycle with `start` high clears all product coordinates (so `prod` reads zero on the following cycle) and captures `b_in` as operand B. Any `a_digit` offered with `a_valid` in that same cycle is not consumed.
- R3: Digit j of A carries coordinate a_(j·W+t) on bit t of `a_digit`. Exactly `ceil(N/W)` digits are consumed per multiplication; with defaults N=11, W=3 that is four digits.
- R4: When the multiplication completes, bit k of `prod` equals the XOR over all i in 0..N−1 of a_i AND b_((k−i) mod N).
- R5: Bits of the final digit whose coordinate index j·W+t is N or more are treated as zero, whatever value is driven on them.
- R6: A cycle in which `a_valid` is low during a multiplication consumes no digit and leaves the accumulated state unchanged. The result equals that of the same digits offered back to back.
- R7: `done` is high for exactly one cycle: the cycle after the edge that consumes the last digit.
- R8: After completion, `prod` holds its value until the next `start`. Digits offered with `a_valid` high while no multiplication is running are ignored and do not raise `done`.
- R9: Multiplying by the ring identity (a_0 = 1, all other coordinates 0) returns B unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication: clear the accumulators and load B |
| b_in | input | N | Operand B coordinates, sampled when `start` is high |
| a_digit | input | W | Next W coordinates of operand A, lowest index in bit 0 |
| a_valid | input | 1 | `a_digit` holds a digit to consume this cycle |
| prod | output | N | Product coordinates in redundant basis |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The embedded properties assume that `start` is never raised together with an in-flight digit that the caller expects to be consumed. They also assume that after `start` the caller supplies digits only through `a_valid`. Under these assumptions the accumulators move only on a consumed digit, and `done` can follow only such a step. The directed tasks keep to this protocol. Every test drives junk on `a_digit` in the `start` cycle, inserts optional gap cycles with `a_valid` low, and drives arbitrary bits in the padding positions of the final digit. After each completion the tasks hold `start` low, so the hold and idle-ignore properties are exercised rather than bypassed.

// File: rtl/rb_mul_pkg.sv
package rb_mul_pkg;

   // Number of W-wide digits that cover N coordinates.
   function automatic int digit_count(input int n, input int w);
      return (n + w - 1) / w;
   endfunction

   // Bits needed to count digit positions 0 .. d-1.
   function automatic int count_bits(input int d);
      return (d > 1) ? $clog2(d) : 1;
   endfunction

endpackage

// File: rtl/rb_bshift.sv
module rb_bshift #(
   parameter int N = 11,
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [N-1:0] b_in,
   output logic [N-1:0] breg
);
   localparam int S = W % N;

   logic [N-1:0] rot;

   generate
      if (S == 0) begin : g_norot
         assign rot = breg;
      end else begin : g_rot
         // new[idx] = old[(idx - S) mod N]
         assign rot = {breg[N-S-1:0], breg[N-1:N-S]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      breg <= '0;
      else if (load)   breg <= b_in;
      else if (shift)  breg <= rot;
   end

   // R3: a rotation moves coordinates, it never creates or drops ones
   a_r3_rotation_keeps_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> ($countones(breg) == $countones($past(breg))));

endmodule

// File: rtl/rb_acc_cell.sv
module rb_acc_cell #(
   parameter int N = 11,
   parameter int W = 3,
   parameter int K = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] digit_m,
   input  logic [N-1:0] breg,
   output logic         q
);
   logic [W-1:0] pp;

   // Partial product for digit bit t uses B coordinate (K - t) mod N.
   generate
      for (genvar t = 0; t < W; t++) begin : g_and
         localparam int IDX = (K + N * W - t) % N;
         assign pp[t] = digit_m[t] & breg[IDX];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (en)  q <= q ^ (^pp);
   end

endmodule

// File: rtl/rb_digit_ctrl.sv
module rb_digit_ctrl
   import rb_mul_pkg::*;
#(
   parameter int N = 11,
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         a_valid,
   input  logic [W-1:0] a_digit,
   output logic         step,
   output logic [W-1:0] digit_m,
   output logic         done
);
   localparam int D  = digit_count(N, W);
   localparam int CW = count_bits(D);

   logic          busy;
   logic [CW-1:0] cnt;

   assign step = busy && a_valid && !start;

   // Zero-pad coordinates that lie past index N-1.
   always_comb begin
      for (int t = 0; t < W; t++) begin
         digit_m[t] = a_digit[t] && ((int'(cnt) * W + t) < N);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
         done <= 1'b0;
      end else if (step) begin
         if (int'(cnt) == D - 1) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b1;
         end else begin
            cnt  <= cnt + 1'b1;
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   // R7: completion is a single-cycle pulse
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion only follows a consumed digit
   a_r7_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(step));

   // R6: a cycle without a valid digit leaves the digit position alone
   a_r6_stall_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_valid && !start) |=> $stable(cnt));

   // R8: no digit is consumed while idle
   a_r8_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |-> !step);

endmodule

// File: rtl/rb_dsmul.sv
module rb_dsmul
   import rb_mul_pkg::*;
#(
   parameter int N = 11,
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] b_in,
   input  logic [W-1:0] a_digit,
   input  logic         a_valid,
   output logic [N-1:0] prod,
   output logic         done
);
   generate
      if (N < 3) begin : g_chk_n
         $error("rb_dsmul: N must be at least 3");
      end
      if (W < 1 || W > N) begin : g_chk_w
         $error("rb_dsmul: W must lie in 1..N");
      end
   endgenerate

   logic         step;
   logic [W-1:0] digit_m;
   logic [N-1:0] breg;

   rb_digit_ctrl #(.N(N), .W(W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .a_valid (a_valid),
      .a_digit (a_digit),
      .step    (step),
      .digit_m (digit_m),
      .done    (done)
   );

   rb_bshift #(.N(N), .W(W)) u_bsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .shift (step),
      .b_in  (b_in),
      .breg  (breg)
   );

   generate
      for (genvar k = 0; k < N; k++) begin : g_cell
         rb_acc_cell #(.N(N), .W(W), .K(k)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (start),
            .en      (step),
            .digit_m (digit_m),
            .breg    (breg),
            .q       (prod[k])
         );
      end
   endgenerate

   // R2: start empties every accumulator
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (prod == '0));

   // R8: without start or a consumed digit the product holds
   a_r8_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !step) |=> $stable(prod));

   // R1: outputs are quiet out of reset
   a_r1_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (prod == '0 && !done));

endmodule

// File: tb/rb_dsmul_test.sv
module rb_dsmul_test;
   localparam int N = 11;
   localparam int W = 3;
   localparam int D = (N + W - 1) / W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] b_in = '0;
   logic [W-1:0] a_digit = '0;
   logic         a_valid = 1'b0;
   logic [N-1:0] prod;
   logic         done;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   rb_dsmul #(.N(N), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .b_in(b_in),
      .a_digit(a_digit), .a_valid(a_valid), .prod(prod), .done(done)
   );

   function automatic logic [N-1:0] model(input logic [N-1:0] a, input logic [N-1:0] b);
      logic [N-1:0] c = '0;
      for (int k = 0; k < N; k++)
         for (int i = 0; i < N; i++)
            c[k] ^= a[i] & b[(k - i + N) % N];
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [N-1:0] act,
                      input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] rnd_elem();
      logic [31:0] r = $urandom;
      return r[N-1:0];
   endfunction

   // One multiplication. gaps: bit j inserts an idle cycle before digit j.
   // junk: value driven on padding bits of the last digit.
   task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                          input logic [D-1:0] gaps, input bit junk, input string req);
      logic [N-1:0] exp = model(a, b);
      logic [N-1:0] held;
      @(negedge clk);
      start = 1'b1; b_in = b; a_valid = 1'b1; a_digit = '1;   // R2: not consumed
      @(negedge clk);
      start = 1'b0;
      chk(prod == '0, "R2 cleared on start", prod, '0);
      for (int j = 0; j < D; j++) begin
         if (gaps[j]) begin
            a_valid = 1'b0; a_digit = '1;                        // R6: stall
            @(negedge clk);
         end
         for (int t = 0; t < W; t++)
            a_digit[t] = (j * W + t < N) ? a[j * W + t] : junk; // R3/R5
         a_valid = 1'b1;
         @(negedge clk);
      end
      a_valid = 1'b0;
      chk(done === 1'b1, {req, " R7 done"}, {{(N-1){1'b0}}, done}, 1);
      chk(prod === exp, {req, " R4 product"}, prod, exp);
      held = prod;
      // R8: idle digits must not disturb the result
      a_valid = 1'b1; a_digit = '1;
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", {{(N-1){1'b0}}, done}, 0);
      @(negedge clk);
      a_valid = 1'b0;
      @(negedge clk);
      chk(prod === held && done === 1'b0, "R8 hold and idle ignore", prod, held);
   endtask

   task automatic t_reset();
      chk(prod === '0, "R1 prod after reset", prod, '0);
      chk(done === 1'b0, "R1 done after reset", {{(N-1){1'b0}}, done}, 0);
   endtask

   task automatic t_identity();
      logic [N-1:0] b = rnd_elem();
      logic [N-1:0] one = {{(N-1){1'b0}}, 1'b1};
      run_mul(one, b, '0, 1'b0, "R9 identity times B");
      run_mul(b, one, '0, 1'b0, "R9 A times identity");
      chk(prod === b, "R9 identity returns operand", prod, b);
   endtask

   task automatic t_random(input int count);
      for (int r = 0; r < count; r++)
         run_mul(rnd_elem(), rnd_elem(), '0, 1'b0, "R4 random");
   endtask

   task automatic t_corners();
      run_mul('1, '1, '0, 1'b0, "R4 all ones");
      run_mul('0, rnd_elem(), '0, 1'b0, "R4 zero operand");
      run_mul({1'b1, {(N-1){1'b0}}}, rnd_elem(), '0, 1'b0, "R3 top coordinate");
   endtask

   task automatic t_stall();
      run_mul(rnd_elem(), rnd_elem(), {D{1'b1}}, 1'b0, "R6 gaps everywhere");
      run_mul(rnd_elem(), rnd_elem(), {{(D-1){1'b0}}, 1'b1} << 1, 1'b0, "R6 one gap");
   endtask

   task automatic t_pad();
      run_mul(rnd_elem(), rnd_elem(), '0, 1'b1, "R5 padding driven high");
      run_mul('1, rnd_elem(), '0, 1'b1, "R5 padding with all ones");
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_identity();
      t_corners();
      t_random(20);
      t_stall();
      t_pad();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule